// File: doc/BRIEF.md
# Per-Processor Masked Interrupt Router

This block gathers 64 level-sensitive device interrupt lines into one raw request word. It then sends that word through four independent 64-bit masks, one for each of four processors. Each processor gets one hard interrupt output. That output is high whenever the processor's mask and the raw word have any set bit in common. A cascaded legacy interrupt controller feeds one fixed bit of the raw word alongside its ordinary device line.

Software reaches the block through a 32-bit register port. The port can read the raw word, read each processor's masked view, and read or write each mask. A 64-bit value moves as two 32-bit accesses that share one half-word latch. On a write, the low half is held in the latch and the high half commits the whole value. On a read, the low half returns bits 31:0 and loads bits 63:32 into the latch, and the high half returns the latch. Acknowledge, priority encoding and vector generation are left to the processor side.

Top module: `cir_irq_router`

## Requirements
- R1: Raw request bit n equals device line n as sampled on the previous clock edge. It is level-sensitive and not held once the line drops.
- R2: Raw request bit 55 is the OR of device line 55 and the legacy controller input, both sampled on the previous edge.
- R3: `cpu_irq[i]` is high exactly when mask i AND the raw word is nonzero. It follows a mask commit or a device line change after one clock edge.
- R4: The mask for processor 0, 1, 2 and 3 is at byte offset 0x200, 0x240, 0x600 and 0x640 respectively. The masked view for processor 0, 1, 2 and 3 is at 0x280, 0x2C0, 0x680 and 0x6C0. The raw word is at 0x300. Address bit 2 selects the high half (bits 63:32).
- R5: A read of a masked-view offset returns mask i AND the raw word.
- R6: A read of offset 0x300 returns the raw word.
- R7: A low-half write stores the write data in the half latch and changes no mask. A high-half write to a mask offset sets that mask to {write data, latch}, and no other mask changes.
- R8: A high-half write to a masked-view or raw offset changes no mask and no output.
- R9: A low-half read returns bits 31:0 and loads bits 63:32 into the half latch. A high-half read returns the latch.
- R10: An access to an unmapped offset raises `acc_err` for one cycle. A read there returns 0xFFFFFFFF. A write there changes neither a mask nor the latch.
- R11: After reset all masks, the raw word, the latch, `acc_rdata`, `acc_err` and every `cpu_irq` are zero.
- R12: `acc_rdata` and `acc_err` update on the clock edge that ends an access, and `acc_rdata` holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 64 | Level device interrupt lines |
| legacy_irq | input | 1 | Cascaded legacy controller output, merged into bit 55 |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| acc_err | output | 1 | Unmapped-offset pulse, registered |
| cpu_irq | output | 4 | Hard interrupt, one per processor, registered |

## Verification
A corrupted mask shows up in two places. The matching `cpu_irq` output goes wrong on the first edge where a raw bit lands on the damaged mask bit. The masked-view read for that processor is also off from that point on. A wrong raw bit is visible within one cycle, in the raw read and in every processor whose mask covers it. A latch that holds the wrong value does not show until the next high-half access, which then commits or returns the wrong upper word. The bench therefore pairs every mask write with a readback and with an output check on the same cycle.

// File: rtl/cir_pkg.sv
package cir_pkg;
    localparam int LINES      = 64;
    localparam int HALF_W     = LINES / 2;
    localparam int NCPU       = 4;
    localparam int CPU_W      = $clog2(NCPU);
    localparam int ADDR_W     = 12;
    localparam int LEGACY_BIT = 55;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_MASK   = 2'd1,
        K_MASKED = 2'd2,
        K_RAW    = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [CPU_W-1:0]   cpu;
        logic               hi;
    } reg_sel_t;
endpackage

// File: rtl/cir_addr_decode.sv
module cir_addr_decode
    import cir_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    logic base_ok;

    always_comb begin
        sel      = '0;
        sel.kind = K_NONE;
        sel.hi   = addr[2];
        sel.cpu  = {addr[10], addr[6]};
        base_ok  = !addr[11] && addr[9] && (addr[5:3] == 3'b000) && (addr[1:0] == 2'b00);
        if (base_ok) begin
            if (!addr[8]) begin
                sel.kind = addr[7] ? K_MASKED : K_MASK;
            end else if (!addr[10] && (addr[7:6] == 2'b00)) begin
                sel.kind = K_RAW;
                sel.cpu  = '0;
            end
        end
    end
endmodule

// File: rtl/cir_mask_bank.sv
module cir_mask_bank
    import cir_pkg::*;
#(
    parameter int N = NCPU,
    parameter int W = LINES,
    localparam int IW = $clog2(N)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [IW-1:0]       commit_cpu,
    input  logic [W-1:0]        commit_val,
    output logic [N-1:0][W-1:0] mask_d,
    output logic [N-1:0][W-1:0] mask_q
);
    logic [N-1:0] touched;

    for (genvar g = 0; g < N; g++) begin : g_mask
        always_comb begin
            touched[g] = commit && (commit_cpu == IW'(g));
            mask_d[g]  = touched[g] ? commit_val : mask_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q[g] <= '0;
            else        mask_q[g] <= mask_d[g];
        end
    end

    // R7: a commit selects at most one mask
    assert_one_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(touched) <= 1);

    // R7: without a commit every mask holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mask_q));
endmodule

// File: rtl/cir_irq_eval.sv
module cir_irq_eval
    import cir_pkg::*;
#(
    parameter int N = NCPU,
    parameter int W = LINES
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0][W-1:0] mask_d,
    input  logic [W-1:0]        raw_d,
    output logic [N-1:0]        irq_q
);
    logic [N-1:0] irq_d;

    for (genvar g = 0; g < N; g++) begin : g_eval
        always_comb irq_d[g] = |(mask_d[g] & raw_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/cir_irq_router.sv
module cir_irq_router
    import cir_pkg::*;
#(
    parameter int LEGACY_LINE = LEGACY_BIT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       dev_irq,
    input  logic              legacy_irq,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [11:0]       acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic              acc_err,
    output logic [3:0]        cpu_irq
);
    typedef struct packed {
        logic [LINES-1:0]  raw;
        logic [HALF_W-1:0] half;
        logic [HALF_W-1:0] rdata;
        logic              err;
    } state_t;

    state_t                      st_d, st_q;
    reg_sel_t                    sel;
    logic                        commit;
    logic [LINES-1:0]            word;
    logic [LINES-1:0]            raw_line;
    logic [NCPU-1:0][LINES-1:0]  mask_d, mask_q;

    cir_addr_decode u_dec (
        .addr (acc_addr),
        .sel  (sel)
    );

    cir_mask_bank #(.N(NCPU), .W(LINES)) u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_cpu (sel.cpu),
        .commit_val ({acc_wdata, st_q.half}),
        .mask_d     (mask_d),
        .mask_q     (mask_q)
    );

    cir_irq_eval #(.N(NCPU), .W(LINES)) u_eval (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_d (mask_d),
        .raw_d  (st_d.raw),
        .irq_q  (cpu_irq)
    );

    always_comb begin
        raw_line              = dev_irq;
        raw_line[LEGACY_LINE] = dev_irq[LEGACY_LINE] | legacy_irq;

        case (sel.kind)
            K_MASK:   word = mask_q[sel.cpu];
            K_MASKED: word = mask_q[sel.cpu] & st_q.raw;
            K_RAW:    word = st_q.raw;
            default:  word = '1;
        endcase

        st_d     = st_q;
        st_d.raw = raw_line;
        st_d.err = 1'b0;
        commit   = 1'b0;

        if (acc_en) begin
            if (sel.kind == K_NONE) begin
                st_d.err = 1'b1;
                if (!acc_we) st_d.rdata = '1;
            end else if (acc_we) begin
                if (!sel.hi)                   st_d.half = acc_wdata;
                else if (sel.kind == K_MASK)   commit    = 1'b1;
            end else begin
                if (sel.hi) begin
                    st_d.rdata = st_q.half;
                end else begin
                    st_d.rdata = word[HALF_W-1:0];
                    st_d.half  = word[LINES-1:HALF_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_rdata = st_q.rdata;
    assign acc_err   = st_q.err;

    localparam logic [LINES-1:0] LEG_MASK = LINES'(1) << LEGACY_LINE;

    // R1: raw word tracks the lines one edge later
    assert_raw_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.raw & ~LEG_MASK) == ($past(dev_irq) & ~LEG_MASK)));

    // R2: legacy input merges into its bit
    assert_legacy_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.raw[LEGACY_LINE] == ($past(dev_irq[LEGACY_LINE]) | $past(legacy_irq))));

    // R3: each output matches its masked request
    for (genvar g = 0; g < NCPU; g++) begin : g_chk
        assert_irq_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[g] == (|(mask_q[g] & st_q.raw)));
    end

    // R8: high-half writes to read-only offsets leave the masks alone
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && sel.hi && (sel.kind == K_MASKED || sel.kind == K_RAW))
        |=> $stable(mask_q));

    // R9: a high-half read returns the latch
    assert_hi_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && sel.hi && sel.kind != K_NONE) |=> (acc_rdata == $past(st_q.half)));

    // R10: unmapped access flags an error and leaves masks and latch alone
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && sel.kind == K_NONE) |=> (acc_err && $stable(mask_q) && $stable(st_q.half)));

    // R10: unmapped read returns all ones
    assert_unmapped_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && sel.kind == K_NONE) |=> (acc_rdata == 32'hFFFF_FFFF));
endmodule

// File: tb/cir_irq_router_tb.sv
`timescale 1ns/1ps
module cir_irq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_irq = '0;
    logic        legacy_irq = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_mask [4];

    always #2.5 clk = ~clk;

    cir_irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .legacy_irq(legacy_irq),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .cpu_irq(cpu_irq)
    );

    function automatic logic [11:0] mask_off(input int i);
        case (i)
            0: return 12'h200;
            1: return 12'h240;
            2: return 12'h600;
            default: return 12'h640;
        endcase
    endfunction

    function automatic logic [11:0] view_off(input int i);
        return mask_off(i) + 12'h080;
    endfunction

    function automatic logic [63:0] raw_model();
        logic [63:0] r = dev_irq;
        r[55] = r[55] | legacy_irq;
        return r;
    endfunction

    function automatic logic [3:0] irq_model();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = |(m_mask[i] & raw_model());
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic wr64(input logic [11:0] a, input logic [63:0] v);
        access(1'b1, a, v[31:0]);
        access(1'b1, a | 12'h004, v[63:32]);
        for (int i = 0; i < 4; i++) if (a == mask_off(i)) m_mask[i] = v;
    endtask

    task automatic rd64(input logic [11:0] a, output logic [63:0] v);
        logic [31:0] lo;
        access(1'b0, a, 32'h0);
        lo = acc_rdata;
        access(1'b0, a | 12'h004, 32'h0);
        v = {acc_rdata, lo};
    endtask

    task automatic set_lines(input logic [63:0] d, input bit leg);
        @(negedge clk);
        dev_irq = d; legacy_irq = leg;
        @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
            report();
        end
    end

    initial begin
        logic [63:0] v, pat;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) m_mask[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset values
        check(cpu_irq == 4'h0, "R11 irq", cpu_irq, 0);
        check(acc_rdata == 32'h0, "R11 rdata", acc_rdata, 0);
        check(acc_err == 1'b0, "R11 err", acc_err, 0);
        for (int i = 0; i < 4; i++) begin
            rd64(mask_off(i), v);
            check(v == 64'h0, "R11 mask", v, 0);
        end
        rd64(12'h300, v);
        check(v == 64'h0, "R11 raw", v, 0);

        // R4 R7: distinct masks, one at a time
        for (int i = 0; i < 4; i++) wr64(mask_off(i), 64'h1111_0000_0000_0001 * (i + 1) ^ (64'h8000_0000_0000_0000 >> i));
        for (int i = 0; i < 4; i++) begin
            rd64(mask_off(i), v);
            check(v == m_mask[i], "R4 R7 mask readback", v, m_mask[i]);
        end

        // R1 R6: raw word
        pat = 64'hA5A5_0F0F_1234_8001;
        set_lines(pat, 1'b0);
        rd64(12'h300, v);
        check(v == raw_model(), "R1 R6 raw read", v, raw_model());
        check(cpu_irq == irq_model(), "R3 irq after lines", cpu_irq, irq_model());
        set_lines(64'h0, 1'b0);
        rd64(12'h300, v);
        check(v == 64'h0, "R1 level not latched", v, 0);

        // R2: legacy merge, R3 latency
        for (int i = 0; i < 4; i++) wr64(mask_off(i), 64'h0);
        wr64(mask_off(2), 64'h0080_0000_0000_0000);
        set_lines(64'h0, 1'b1);
        rd64(12'h300, v);
        check(v == 64'h0080_0000_0000_0000, "R2 legacy bit", v, 64'h0080_0000_0000_0000);
        check(cpu_irq == 4'b0100, "R2 R3 legacy irq", cpu_irq, 4'b0100);
        set_lines(64'h0, 1'b0);
        check(cpu_irq == 4'b0000, "R3 legacy drop", cpu_irq, 0);

        wr64(mask_off(0), 64'h8);
        @(negedge clk);
        dev_irq = 64'h8;
        #1;
        check(cpu_irq[0] == 1'b0, "R3 no early rise", cpu_irq, 0);
        @(negedge clk);
        check(cpu_irq == 4'b0001, "R3 one-edge rise", cpu_irq, 4'b0001);
        dev_irq = 64'h0;
        @(negedge clk);
        check(cpu_irq == 4'b0000, "R3 one-edge fall", cpu_irq, 0);

        // R5: masked view
        set_lines(64'hFFFF_0000_00FF_0008, 1'b0);
        wr64(mask_off(1), 64'h0F0F_0F0F_0F0F_0F0F);
        for (int i = 0; i < 4; i++) begin
            rd64(view_off(i), v);
            check(v == (m_mask[i] & raw_model()), "R5 masked view", v, m_mask[i] & raw_model());
        end

        // R8: writes to read-only offsets ignored
        wr64(view_off(0), 64'hFFFF_FFFF_FFFF_FFFF);
        wr64(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        check(cpu_irq == irq_model(), "R8 irq unchanged", cpu_irq, irq_model());
        for (int i = 0; i < 4; i++) begin
            rd64(mask_off(i), v);
            check(v == m_mask[i], "R8 mask unchanged", v, m_mask[i]);
        end

        // R7 R9: low write alone, latch from read
        access(1'b1, mask_off(3), 32'hDEAD_BEEF);
        rd64(mask_off(3), v);
        check(v == m_mask[3], "R7 low half no commit", v, m_mask[3]);
        access(1'b0, mask_off(1), 32'h0);
        check(acc_rdata == m_mask[1][31:0], "R9 low read", acc_rdata, m_mask[1][31:0]);
        access(1'b0, mask_off(0) | 12'h004, 32'h0);
        check(acc_rdata == m_mask[1][63:32], "R9 latch read", acc_rdata, m_mask[1][63:32]);

        // R10: unmapped offsets
        access(1'b0, 12'h100, 32'h0);
        check(acc_rdata == 32'hFFFF_FFFF, "R10 read ones", acc_rdata, 32'hFFFF_FFFF);
        check(acc_err == 1'b1, "R10 err", acc_err, 1);
        @(negedge clk);
        check(acc_err == 1'b0, "R10 err pulse", acc_err, 0);
        // R12: rdata holds after an access
        check(acc_rdata == 32'hFFFF_FFFF, "R12 hold", acc_rdata, 32'hFFFF_FFFF);
        access(1'b1, mask_off(2), 32'h1357_9BDF);
        access(1'b1, 12'h308, 32'h0000_0000);
        check(acc_err == 1'b1, "R10 write err", acc_err, 1);
        access(1'b1, 12'h0C4, 32'hFFFF_0000);
        access(1'b1, mask_off(2) | 12'h004, 32'h2468_ACE0);
        m_mask[2] = 64'h2468_ACE0_1357_9BDF;
        for (int i = 0; i < 4; i++) begin
            rd64(mask_off(i), v);
            check(v == m_mask[i], "R10 latch and masks kept", v, m_mask[i]);
        end

        // random mix: R1 R3 R5 R6 R7
        for (int it = 0; it < 300; it++) begin
            int c;
            logic [63:0] d, mv;
            d  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            set_lines(d, 1'($urandom));
            c  = int'($urandom % 4);
            mv = {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom % 2 == 0) wr64(mask_off(c), mv);
            check(cpu_irq == irq_model(), "R3 random irq", cpu_irq, irq_model());
            rd64(view_off(c), v);
            check(v == (m_mask[c] & raw_model()), "R5 random view", v, m_mask[c] & raw_model());
            if (it % 10 == 0) begin
                rd64(12'h300, v);
                check(v == raw_model(), "R6 random raw", v, raw_model());
                rd64(mask_off(c), v);
                check(v == m_mask[c], "R7 random mask", v, m_mask[c]);
            end
        end

        done = 1'b1;
        report();
    end
endmodule